// File: doc/BRIEF.md
# Wide-Bus Initiator Lane Steering

This block sits in the data path of a bus initiator that can run transfers on a 64-bit parallel bus. For a write it takes 64-bit words and their active-low byte-enable masks from an internal buffer. It raises the 64-bit request strobe and waits for the target to claim the cycle. At that point it learns whether the target has also accepted the wide extension. A wide target gets each word in a single data phase across both lanes. A narrow target gets each word as two phases on the low lane, with the upper half of the word moved down for the second phase.

For reads the block issues no data. It drives every byte enable active and reports whether the transfer runs wide. When the transfer is wide, it checks the target's upper-lane parity one clock after each completed data phase. A write whose last word holds only its low DWORD ends with the upper byte enables forced inactive. On a wide target the upper data lane is still driven with defined levels. On a narrow target the empty upper phase is skipped.

The buffer interface is simple: the block raises `buf_pop` in a cycle where the head entry is consumed, and the buffer advances at that clock edge. For reads, buffer entries carry only the final-phase marker. Bus control, arbitration, retry and disconnect are handled elsewhere.

Top module: `pci64_lane_steer`

## Requirements
- R1: While reset is asserted and while no transfer is active, `req64_n` is 1, `hi_en` is 0, `buf_pop` is 0, `wide_mode` is 0 and `par64_err` is 0.
- R2: In the cycle after `xfer_start`, `req64_n` goes to 0 for a write (`xfer_write`=1) or for a prefetchable read (`xfer_pref`=1). It stays 1 for a non-prefetchable read.
- R3: When `ack64_n` and `devsel_n` are both sampled low, a write word is driven in one phase: `ad_out` = {data[63:32], data[31:0]}, `cbe_out` = {be[7:4], be[3:0]}, `hi_en`=1, and one pop occurs per completed phase.
- R4: When `devsel_n` is sampled low without `ack64_n`, each write word takes two phases. The first phase puts data[31:0]/be[3:0] on the low lane. The second puts data[63:32]/be[7:4] on the low lane. The upper lane and upper enables are 0, `hi_en` is 0, and the pop comes only with the second phase.
- R5: If the head word is the last one (`buf_last`) and holds only its low DWORD (`buf_odd`), a wide write drives `cbe_out[7:4]`=4'hF while `ad_out[63:32]` still carries the word's upper data. A narrow write ends after that word's first phase, with the pop in that phase.
- R6: During a read, `cbe_out` is all zeros and `ad_out` is zero on both lanes whatever the width. Every completed phase pops one entry.
- R7: A phase completes only in a cycle where `irdy_n` and `trdy_n` are both 0. Otherwise there is no pop, and the outputs and the half-word position hold.
- R8: `wide_mode` is 1 from the cycle after the claim until the transfer ends, only if 64-bit was requested and `ack64_n` was low together with `devsel_n`. It is 0 for a non-prefetchable read even if `ack64_n` is low.
- R9: In the cycle after any cycle where a write drives the upper lane (`hi_en`=1), `par64` equals the XOR of that cycle's `ad_out[63:32]` and `cbe_out[7:4]` (even parity). Otherwise it holds.
- R10: After a completed wide read phase, `par64_in` is compared one cycle later with the XOR of the phase's `ad_in_hi` and upper enables. `par64_err` is 1 in the following cycle if they differ, and 0 otherwise.
- R11: After the pop of a `buf_last` entry, the block returns to idle in the next cycle: `req64_n`=1, `hi_en`=0, `wide_mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | One-cycle pulse that opens a transfer |
| xfer_write | input | 1 | 1 for a write transfer, 0 for a read |
| xfer_pref | input | 1 | Read targets prefetchable memory (may go wide) |
| devsel_n | input | 1 | Target claim, active low |
| ack64_n | input | 1 | Target accepts the 64-bit extension, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| buf_data | input | 64 | Head write word from the buffer |
| buf_be | input | 8 | Head byte enables, active low |
| buf_last | input | 1 | Head entry is the final one |
| buf_odd | input | 1 | Final word holds only its low DWORD |
| buf_pop | output | 1 | Head entry consumed at this clock edge |
| ad_in_hi | input | 32 | Upper read data lane from the bus |
| par64_in | input | 1 | Upper-lane parity from the target |
| req64_n | output | 1 | 64-bit request, active low |
| ad_out | output | 64 | Address/data lanes driven by the initiator |
| cbe_out | output | 8 | Byte enables driven, active low |
| hi_en | output | 1 | Upper lane and upper enables in use |
| wide_mode | output | 1 | Transfer running 64 bits per phase |
| par64 | output | 1 | Upper-lane even parity for writes |
| par64_err | output | 1 | Upper-lane read parity mismatch |

## Verification
The lane outputs, `hi_en` and `buf_pop` are combinational from the registered phase state and the current inputs, so they are checked in the same cycle the inputs are applied. `req64_n` follows `xfer_start` by one clock. `wide_mode` follows the claim sample by one clock, and `par64` follows the upper-lane cycle it covers by one clock. `par64_err` appears two clocks after the read phase: one clock for the target's parity to arrive and one to register the comparison. The bench drives every input just after a falling edge and reads outputs one nanosecond later. Each check is placed after exactly the number of rising edges listed above, and the buffer model advances only on edges where the block popped.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLAIM = 2'd1,
    PH_DATA  = 2'd2
  } ph_state_e;
endpackage

// File: rtl/ls_phase_ctrl.sv
module ls_phase_ctrl
  import lane_steer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      xfer_start,
  input  logic      xfer_write,
  input  logic      xfer_pref,
  input  logic      devsel_n,
  input  logic      ack64_n,
  input  logic      irdy_n,
  input  logic      trdy_n,
  input  logic      buf_last,
  input  logic      buf_odd,
  output ph_state_e st,
  output logic      wr_mode,
  output logic      req_on,
  output logic      wide,
  output logic      half,
  output logic      drive_wide,
  output logic      beat,
  output logic      pop
);
  ph_state_e st_q, st_d;
  logic wr_q, wr_d, req_q, req_d, wide_q, wide_d, half_q, half_d;
  logic ld_en, end_odd;

  assign end_odd = buf_last & buf_odd;
  assign beat    = (st_q == PH_DATA) & ~irdy_n & ~trdy_n;
  // consume the head word when its last (or only) phase completes
  assign pop     = beat & (wide_q | ~wr_q | half_q | end_odd);
  assign ld_en   = (st_q == PH_IDLE) & xfer_start;

  always_comb begin
    st_d   = st_q;
    wr_d   = wr_q;
    req_d  = req_q;
    wide_d = wide_q;
    half_d = half_q;
    case (st_q)
      PH_IDLE: begin
        if (ld_en) begin
          st_d   = PH_CLAIM;
          wr_d   = xfer_write;
          req_d  = xfer_write | xfer_pref;
          wide_d = 1'b0;
          half_d = 1'b0;
        end
      end
      PH_CLAIM: begin
        if (!devsel_n) begin
          st_d   = PH_DATA;
          wide_d = req_q & ~ack64_n;
        end
      end
      PH_DATA: begin
        if (pop) begin
          half_d = 1'b0;
          if (buf_last) begin
            st_d   = PH_IDLE;
            req_d  = 1'b0;
            wide_d = 1'b0;
          end
        end else if (beat) begin
          half_d = 1'b1;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      wr_q   <= 1'b0;
      req_q  <= 1'b0;
      wide_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      req_q  <= req_d;
      wide_q <= wide_d;
      half_q <= half_d;
      if (ld_en) begin
        wr_q <= wr_d;
      end
    end
  end

  always_comb begin
    case (st_q)
      PH_CLAIM: drive_wide = req_q;
      PH_DATA:  drive_wide = wide_q;
      default:  drive_wide = 1'b0;
    endcase
  end

  assign st      = st_q;
  assign wr_mode = wr_q;
  assign req_on  = req_q;
  assign wide    = wide_q;
  assign half    = half_q;
endmodule

// File: rtl/ls_lane_mux.sv
module ls_lane_mux #(
  parameter int HALF_W = 32,
  localparam int BEH = HALF_W / 8,
  localparam int DW  = 2 * HALF_W,
  localparam int BW  = 2 * BEH
) (
  input  logic          active,
  input  logic          wr_mode,
  input  logic          drive_wide,
  input  logic          half,
  input  logic          end_odd,
  input  logic [DW-1:0] buf_data,
  input  logic [BW-1:0] buf_be,
  output logic [DW-1:0] ad,
  output logic [BW-1:0] cbe,
  output logic          hi_en
);
  logic [HALF_W-1:0] d_lo, d_hi;
  logic [BEH-1:0]    b_lo, b_hi, b_hi_m;

  assign d_lo = buf_data[HALF_W-1:0];
  assign d_hi = buf_data[DW-1:HALF_W];
  assign b_lo = buf_be[BEH-1:0];
  assign b_hi = buf_be[BW-1:BEH];

  // upper enables go inactive when the final word has no upper DWORD
  for (genvar g = 0; g < BEH; g++) begin : g_mask
    assign b_hi_m[g] = end_odd | b_hi[g];
  end

  assign hi_en = active & drive_wide;

  always_comb begin
    ad  = '0;
    cbe = '0;
    if (active && wr_mode) begin
      if (drive_wide) begin
        ad  = {d_hi, d_lo};
        cbe = {b_hi_m, b_lo};
      end else begin
        ad  = {{HALF_W{1'b0}}, (half ? d_hi : d_lo)};
        cbe = {{BEH{1'b0}}, (half ? b_hi : b_lo)};
      end
    end
  end
endmodule

// File: rtl/ls_par64.sv
module ls_par64 #(
  parameter int HALF_W = 32,
  localparam int BEH = HALF_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  logic [HALF_W-1:0] ad_hi,
  input  logic [BEH-1:0]    cbe_hi,
  input  logic              chk_en,
  input  logic [HALF_W-1:0] ad_in_hi,
  input  logic              par64_in,
  output logic              par64,
  output logic              par64_err
);
  logic par_q, par_d, pend_q, exp_q, exp_d, err_q, err_d;

  always_comb begin
    par_d = ^{ad_hi, cbe_hi};
    exp_d = ^{ad_in_hi, cbe_hi};
    err_d = pend_q & (exp_q ^ par64_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q  <= 1'b0;
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (gen_en) begin
        par_q <= par_d;
      end
      if (chk_en) begin
        exp_q <= exp_d;
      end
      pend_q <= chk_en;
      err_q  <= err_d;
    end
  end

  assign par64     = par_q;
  assign par64_err = err_q;
endmodule

// File: rtl/pci64_lane_steer.sv
module pci64_lane_steer
  import lane_steer_pkg::*;
#(
  parameter int HALF_W = 32,
  localparam int BEH = HALF_W / 8,
  localparam int DW  = 2 * HALF_W,
  localparam int BW  = 2 * BEH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              xfer_write,
  input  logic              xfer_pref,
  input  logic              devsel_n,
  input  logic              ack64_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic [DW-1:0]     buf_data,
  input  logic [BW-1:0]     buf_be,
  input  logic              buf_last,
  input  logic              buf_odd,
  output logic              buf_pop,
  input  logic [HALF_W-1:0] ad_in_hi,
  input  logic              par64_in,
  output logic              req64_n,
  output logic [DW-1:0]     ad_out,
  output logic [BW-1:0]     cbe_out,
  output logic              hi_en,
  output logic              wide_mode,
  output logic              par64,
  output logic              par64_err
);
  ph_state_e st;
  logic wr_mode, req_on, wide, half, drive_wide, beat, active, in_data;

  ls_phase_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .xfer_write (xfer_write),
    .xfer_pref  (xfer_pref),
    .devsel_n   (devsel_n),
    .ack64_n    (ack64_n),
    .irdy_n     (irdy_n),
    .trdy_n     (trdy_n),
    .buf_last   (buf_last),
    .buf_odd    (buf_odd),
    .st         (st),
    .wr_mode    (wr_mode),
    .req_on     (req_on),
    .wide       (wide),
    .half       (half),
    .drive_wide (drive_wide),
    .beat       (beat),
    .pop        (buf_pop)
  );

  assign active  = (st != PH_IDLE);
  assign in_data = (st == PH_DATA);

  ls_lane_mux #(.HALF_W(HALF_W)) u_mux (
    .active     (active),
    .wr_mode    (wr_mode),
    .drive_wide (drive_wide),
    .half       (half),
    .end_odd    (buf_last & buf_odd),
    .buf_data   (buf_data),
    .buf_be     (buf_be),
    .ad         (ad_out),
    .cbe        (cbe_out),
    .hi_en      (hi_en)
  );

  ls_par64 #(.HALF_W(HALF_W)) u_par (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (hi_en & wr_mode),
    .ad_hi     (ad_out[DW-1:HALF_W]),
    .cbe_hi    (cbe_out[BW-1:BEH]),
    .chk_en    (beat & ~wr_mode & wide),
    .ad_in_hi  (ad_in_hi),
    .par64_in  (par64_in),
    .par64     (par64),
    .par64_err (par64_err)
  );

  assign req64_n   = ~req_on;
  assign wide_mode = wide;
endmodule

// File: rtl/pci64_lane_steer_chk.sv
module pci64_lane_steer_chk #(
  parameter int HALF_W = 32,
  localparam int BEH = HALF_W / 8,
  localparam int DW  = 2 * HALF_W,
  localparam int BW  = 2 * BEH
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req64_n,
  input logic          hi_en,
  input logic [DW-1:0] ad_out,
  input logic [BW-1:0] cbe_out,
  input logic          buf_pop,
  input logic          buf_last,
  input logic          buf_odd,
  input logic          irdy_n,
  input logic          trdy_n,
  input logic          wide_mode,
  input logic          par64,
  input logic          wr_mode,
  input logic          in_data
);
  // R1
  upper_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req64_n |-> !hi_en);

  // R4
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en |-> (ad_out[DW-1:HALF_W] == '0 && cbe_out[BW-1:BEH] == '0));

  // R5
  odd_end_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en && wr_mode && wide_mode && buf_last && buf_odd) |-> (cbe_out[BW-1:BEH] == '1));

  // R6
  read_be_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !wr_mode) |-> (cbe_out == '0));

  // R7
  stall_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_n || trdy_n) |-> !buf_pop);

  // R9
  par64_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hi_en && wr_mode) |-> (par64 == ^{$past(ad_out[DW-1:HALF_W]), $past(cbe_out[BW-1:BEH])}));

  // R11
  last_pop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_pop && buf_last) |=> (req64_n && !wide_mode));
endmodule

bind pci64_lane_steer pci64_lane_steer_chk #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req64_n   (req64_n),
  .hi_en     (hi_en),
  .ad_out    (ad_out),
  .cbe_out   (cbe_out),
  .buf_pop   (buf_pop),
  .buf_last  (buf_last),
  .buf_odd   (buf_odd),
  .irdy_n    (irdy_n),
  .trdy_n    (trdy_n),
  .wide_mode (wide_mode),
  .par64     (par64),
  .wr_mode   (wr_mode),
  .in_data   (in_data)
);

// File: tb/sim_pci64_lane_steer.sv
`timescale 1ns/1ps
module sim_pci64_lane_steer;
  logic        clk, rst_n;
  logic        xfer_start, xfer_write, xfer_pref;
  logic        devsel_n, ack64_n, irdy_n, trdy_n;
  logic [63:0] buf_data;
  logic [7:0]  buf_be;
  logic        buf_last, buf_odd, buf_pop;
  logic [31:0] ad_in_hi;
  logic        par64_in;
  logic        req64_n;
  logic [63:0] ad_out;
  logic [7:0]  cbe_out;
  logic        hi_en, wide_mode, par64, par64_err;

  int checks = 0;
  int errors = 0;

  logic [63:0] mem_d  [0:3];
  logic [7:0]  mem_be [0:3];
  logic        mem_last [0:3];
  logic        mem_odd  [0:3];
  int          idx;
  logic        buf_clr;

  pci64_lane_steer u0 (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_write(xfer_write),
    .xfer_pref(xfer_pref), .devsel_n(devsel_n), .ack64_n(ack64_n),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .buf_data(buf_data), .buf_be(buf_be),
    .buf_last(buf_last), .buf_odd(buf_odd), .buf_pop(buf_pop),
    .ad_in_hi(ad_in_hi), .par64_in(par64_in), .req64_n(req64_n),
    .ad_out(ad_out), .cbe_out(cbe_out), .hi_en(hi_en), .wide_mode(wide_mode),
    .par64(par64), .par64_err(par64_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // buffer model: advance on edges where the block popped
  always @(posedge clk) begin
    if (buf_clr) idx <= 0;
    else if (buf_pop) idx <= idx + 1;
  end
  assign buf_data = mem_d[idx & 3];
  assign buf_be   = mem_be[idx & 3];
  assign buf_last = mem_last[idx & 3];
  assign buf_odd  = mem_odd[idx & 3];

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_idle();
    xfer_start = 0; xfer_write = 0; xfer_pref = 0;
    devsel_n = 1; ack64_n = 1; irdy_n = 1; trdy_n = 1;
    ad_in_hi = '0; par64_in = 0;
  endtask

  task automatic load(input int n);
    for (int i = 0; i < 4; i++) begin
      mem_last[i] = (i == n - 1);
      mem_odd[i]  = 1'b0;
    end
    buf_clr = 1;
    tick();
    buf_clr = 0;
  endtask

  // open a transfer, leave the block in its claim cycle
  task automatic open_xfer(input logic wr, input logic pf);
    xfer_start = 1; xfer_write = wr; xfer_pref = pf;
    tick();
    xfer_start = 0;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 0; buf_clr = 1;
    bus_idle();
    for (int i = 0; i < 4; i++) begin
      mem_d[i] = '0; mem_be[i] = '0; mem_last[i] = 0; mem_odd[i] = 0;
    end
    repeat (3) tick();
    #1;
    chk("R1", "req64_n in reset", req64_n, 1);
    chk("R1", "hi_en in reset", hi_en, 0);
    chk("R1", "buf_pop in reset", buf_pop, 0);
    chk("R1", "wide_mode in reset", wide_mode, 0);
    chk("R1", "par64_err in reset", par64_err, 0);
    rst_n = 1; buf_clr = 0;
    tick();
  endtask

  task automatic t_write_wide();
    logic [63:0] d0 = 64'hA1B2C3D4_11223344, d1 = 64'h0F0E0D0C_55667788;
    logic [7:0]  b0 = 8'h3C, b1 = 8'h81;
    mem_d[0] = d0; mem_be[0] = b0; mem_d[1] = d1; mem_be[1] = b1;
    load(2);
    open_xfer(1, 0);
    chk("R2", "req64_n after write start", req64_n, 0);
    devsel_n = 0; ack64_n = 0;
    tick(); irdy_n = 0; trdy_n = 1; #1;
    chk("R8", "wide_mode after ack64", wide_mode, 1);
    chk("R3", "wide ad word0", ad_out, d0);
    chk("R3", "wide cbe word0", cbe_out, b0);
    chk("R3", "hi_en wide", hi_en, 1);
    chk("R7", "no pop while target stalls", buf_pop, 0);
    chk("R9", "par64 after claim cycle", par64, ^{d0[63:32], b0[7:4]});
    tick(); #1;
    chk("R7", "stalled ad holds", ad_out, d0);
    trdy_n = 0; #1;
    chk("R3", "pop on completed wide phase", buf_pop, 1);
    tick(); #1;
    chk("R3", "wide ad word1", ad_out, d1);
    chk("R3", "wide cbe word1", cbe_out, b1);
    chk("R3", "pop word1", buf_pop, 1);
    tick(); #1;
    chk("R11", "req64_n released", req64_n, 1);
    chk("R11", "hi_en off at end", hi_en, 0);
    chk("R11", "wide_mode off at end", wide_mode, 0);
    chk("R9", "par64 of last wide phase", par64, ^{d1[63:32], b1[7:4]});
    bus_idle();
    tick();
  endtask

  task automatic t_write_narrow();
    logic [63:0] d0 = 64'hDEADBEEF_CAFEF00D, d1 = 64'h13572468_9ABCDEF0;
    logic [7:0]  b0 = 8'h5A, b1 = 8'hC3;
    mem_d[0] = d0; mem_be[0] = b0; mem_d[1] = d1; mem_be[1] = b1;
    load(2);
    open_xfer(1, 0);
    devsel_n = 0; ack64_n = 1;
    tick(); irdy_n = 0; trdy_n = 0; #1;
    chk("R8", "wide_mode without ack64", wide_mode, 0);
    chk("R4", "narrow phase1 ad", ad_out, {32'h0, d0[31:0]});
    chk("R4", "narrow phase1 cbe", cbe_out, {4'h0, b0[3:0]});
    chk("R4", "narrow hi_en", hi_en, 0);
    chk("R4", "no pop after first half", buf_pop, 0);
    tick(); trdy_n = 1; #1;
    chk("R4", "narrow phase2 redirect ad", ad_out, {32'h0, d0[63:32]});
    chk("R4", "narrow phase2 redirect cbe", cbe_out, {4'h0, b0[7:4]});
    chk("R7", "no pop on stall in second half", buf_pop, 0);
    tick(); #1;
    chk("R7", "half position held over stall", ad_out, {32'h0, d0[63:32]});
    trdy_n = 0; #1;
    chk("R4", "pop after second half", buf_pop, 1);
    tick(); #1;
    chk("R4", "word1 low half", ad_out, {32'h0, d1[31:0]});
    tick(); #1;
    chk("R4", "word1 high half", cbe_out, {4'h0, b1[7:4]});
    chk("R4", "word1 pop", buf_pop, 1);
    tick(); #1;
    chk("R11", "narrow write ends", req64_n, 1);
    bus_idle();
    tick();
  endtask

  task automatic t_write_odd_wide();
    logic [63:0] d0 = 64'h76543210_89ABCDEF;
    mem_d[0] = d0; mem_be[0] = 8'h00;
    load(1); mem_odd[0] = 1;
    open_xfer(1, 0);
    devsel_n = 0; ack64_n = 0;
    tick(); irdy_n = 0; trdy_n = 0; #1;
    chk("R5", "odd end upper enables inactive", cbe_out, 8'hF0);
    chk("R5", "odd end upper data still driven", ad_out, d0);
    chk("R5", "odd end single pop", buf_pop, 1);
    tick(); #1;
    chk("R9", "par64 with masked enables", par64, ^{d0[63:32], 4'hF});
    chk("R11", "odd wide end", req64_n, 1);
    bus_idle();
    tick();
  endtask

  task automatic t_write_odd_narrow();
    logic [63:0] d0 = 64'h11112222_33334444, d1 = 64'h55556666_77778888;
    mem_d[0] = d0; mem_be[0] = 8'h12; mem_d[1] = d1; mem_be[1] = 8'h34;
    load(2); mem_odd[1] = 1;
    open_xfer(1, 0);
    devsel_n = 0;
    tick(); irdy_n = 0; trdy_n = 0;
    tick(); #1;
    chk("R4", "odd narrow word0 upper half", ad_out, {32'h0, d0[63:32]});
    tick(); #1;
    chk("R5", "odd narrow final low half", ad_out, {32'h0, d1[31:0]});
    chk("R5", "odd narrow final cbe", cbe_out, 8'h04);
    chk("R5", "odd narrow pop on first half", buf_pop, 1);
    tick(); #1;
    chk("R5", "odd narrow ends without upper half", req64_n, 1);
    chk("R5", "odd narrow no extra pop", buf_pop, 0);
    bus_idle();
    tick();
  endtask

  task automatic t_read_wide();
    mem_d[0] = 64'hFFFF_FFFF_FFFF_FFFF; mem_be[0] = 8'hFF;
    mem_d[1] = 64'hFFFF_FFFF_FFFF_FFFF; mem_be[1] = 8'hFF;
    load(2);
    open_xfer(0, 1);
    chk("R2", "req64_n on prefetchable read", req64_n, 0);
    devsel_n = 0; ack64_n = 0;
    tick(); irdy_n = 0; trdy_n = 0; ad_in_hi = 32'h0000_0007; #1;
    chk("R8", "wide read", wide_mode, 1);
    chk("R6", "read cbe all active", cbe_out, 8'h00);
    chk("R6", "read ad not driven", ad_out, 64'h0);
    chk("R6", "read pop phase0", buf_pop, 1);
    tick(); ad_in_hi = 32'h0000_0003; par64_in = 1; #1;
    chk("R6", "read pop phase1", buf_pop, 1);
    tick(); par64_in = 1; irdy_n = 1; trdy_n = 1; #1;
    chk("R10", "good parity no error", par64_err, 0);
    tick(); #1;
    chk("R10", "bad parity flagged", par64_err, 1);
    chk("R11", "read ended", req64_n, 1);
    tick(); #1;
    chk("R10", "error clears", par64_err, 0);
    bus_idle();
    tick();
  endtask

  task automatic t_read_np();
    load(1);
    open_xfer(0, 0);
    chk("R2", "no req64 on non-prefetchable read", req64_n, 1);
    devsel_n = 0; ack64_n = 0;
    tick(); irdy_n = 0; trdy_n = 0; #1;
    chk("R8", "ack64 ignored without request", wide_mode, 0);
    chk("R6", "np read hi_en", hi_en, 0);
    chk("R6", "np read cbe", cbe_out, 8'h00);
    chk("R6", "np read pop", buf_pop, 1);
    bus_idle();
    tick(); tick();
  endtask

  task automatic t_read_narrow();
    load(2);
    open_xfer(0, 1);
    devsel_n = 0; ack64_n = 1;
    tick(); irdy_n = 0; trdy_n = 0; #1;
    chk("R8", "narrow read width", wide_mode, 0);
    chk("R6", "narrow read no redirect ad", ad_out, 64'h0);
    chk("R6", "narrow read pop phase0", buf_pop, 1);
    tick(); #1;
    chk("R6", "narrow read pop phase1", buf_pop, 1);
    chk("R6", "narrow read cbe", cbe_out, 8'h00);
    tick(); #1;
    chk("R10", "no parity error on narrow read", par64_err, 0);
    bus_idle();
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_write_wide();
    t_write_narrow();
    t_write_odd_wide();
    t_write_odd_narrow();
    t_read_wide();
    t_read_np();
    t_read_narrow();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule